// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit owns a 64-bit product/accumulator register for a 32-bit core. The register is read as a high word (`mach_o`) and a low word (`macl_o`). A caller presents an operation code, two 32-bit operands that have already been fetched, and a saturate flag, then pulses `start_i` for one cycle. The unit covers five plain multiplies and two accumulate forms, and it can load either half of the register on its own. The accumulate forms can clamp their result to 48 or 32 bits.

Every accepted operation completes a fixed `LAT` clock edges after the edge that sampled `start_i`. On that same edge the accumulator updates and `done_o` rises for one cycle. `busy_o` stays high from acceptance through completion. Any start seen while busy is dropped. Reading either half of the register is a plain read of the output ports.

Top module: `mac_unit`

## Requirements
- R1: Code 0 (low multiply) writes bits 31:0 of the 32x32 product of the operands into the low word. The high word is kept.
- R2: Code 1 multiplies the zero-extended low 16 bits of each operand. Code 2 multiplies the sign-extended low 16 bits. Each writes the 32-bit product to the low word and keeps the high word.
- R3: Code 3 writes the full unsigned 64-bit product of the two operands to the register. Code 4 writes the full signed 64-bit product.
- R4: Code 5 with the saturate flag low adds the signed 64-bit product of the operands to the whole 64-bit register, wrapping on overflow.
- R5: Code 5 with the saturate flag high adds the product to the sign-extended bits 47:0 of the register. The sum is clamped to the range -2^47 .. 2^47-1 and written to bits 47:0. Bits 63:48 are kept.
- R6: Code 6 with the saturate flag low adds the signed product of the sign-extended low halfwords, itself sign-extended to 64 bits, to the whole register.
- R7: Code 6 with the saturate flag high adds that product to the signed low word and clamps the sum to the signed 32-bit range. On a clamp, bit 32 of the register (bit 0 of the high word) is set. Bits 63:33 are always kept, and bit 32 is kept when no clamp occurs.
- R8: Code 7 loads operand A into the high word and keeps the low word. Code 8 loads operand A into the low word and keeps the high word.
- R9: The register and `done_o` update on the `LAT`-th rising edge after the edge that samples `start_i` while idle. `done_o` is a single-cycle pulse. `busy_o` is high from the accepting edge until that completion edge.
- R10: A start raised while `busy_o` is high is ignored. Codes 9 to 15 complete with normal timing and leave the register unchanged.
- R11: After reset the register is zero, and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation (sampled while idle) |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| sat_i | input | 1 | Saturate flag for the accumulate forms |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| mach_o | output | 32 | Register bits 63:32 |
| macl_o | output | 32 | Register bits 31:0 |

## Verification
The sweep crosses every operation with eight operand corner values and five register presets. The presets sit close to the 48-bit and 32-bit limits in both directions, so the clamping paths are reached in both directions.

The failures it targets are these:
- A clamp bound off by one, or a clamp on the wrong side.
- A saturated 48-bit sum that overwrites bits 63:48.
- A 16-bit clamp that forgets to set the overflow bit or clears it.
- Partial-write forms that disturb the other word.
- Signed and unsigned extension mixed up in the 16-bit and 64-bit forms.

Separate checks cover three further cases: a start issued mid-operation that overwrote the register or gave a second done, an unused code that changed the register, and a latency off by a cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ACC_W  = 2 * WORD_W;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MUL32  = 4'd0,
    OP_MULU16 = 4'd1,
    OP_MULS16 = 4'd2,
    OP_DMULU  = 4'd3,
    OP_DMULS  = 4'd4,
    OP_MAC32  = 4'd5,
    OP_MAC16  = 4'd6,
    OP_LDH    = 4'd7,
    OP_LDL    = 4'd8
  } mac_op_e;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl #(
  parameter int unsigned LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic fire_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (LAT < 2) ? 1 : $clog2(LAT);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;

  assign accept_o = start_i && !busy_q;
  assign fire_o   = busy_q && (cnt_q == '0);
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= fire_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(LAT - 1);
      end else if (fire_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fire_o) |=> busy_o);
endmodule

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [ACC_W-1:0]  prod_o
);
  logic signed [ACC_W-1:0] xa, xb, p;

  // operand extension picks signed/unsigned and width per code
  always_comb begin
    unique case (op_i)
      OP_MULU16: begin
        xa = {48'b0, a_i[15:0]};
        xb = {48'b0, b_i[15:0]};
      end
      OP_MULS16, OP_MAC16: begin
        xa = {{48{a_i[15]}}, a_i[15:0]};
        xb = {{48{b_i[15]}}, b_i[15:0]};
      end
      OP_DMULS, OP_MAC32: begin
        xa = {{32{a_i[31]}}, a_i};
        xb = {{32{b_i[31]}}, b_i};
      end
      default: begin
        xa = {32'b0, a_i};
        xb = {32'b0, b_i};
      end
    endcase
  end

  assign p      = xa * xb;
  assign prod_o = p;
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic              sat_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [ACC_W-1:0]  prod_i,
  input  logic [ACC_W-1:0]  mac_i,
  output logic [ACC_W-1:0]  mac_o
);
  logic [ACC_W-1:0] s48;
  logic [32:0]      s33;
  logic             ovf48, ovf32;

  always_comb begin
    s48   = {{16{mac_i[47]}}, mac_i[47:0]} + prod_i;
    s33   = {mac_i[31], mac_i[31:0]} + {prod_i[31], prod_i[31:0]};
    ovf48 = (s48[63:47] != {17{s48[63]}});
    ovf32 = s33[32] ^ s33[31];
    mac_o = mac_i;
    unique case (op_i)
      OP_MUL32, OP_MULU16, OP_MULS16: mac_o[31:0] = prod_i[31:0];
      OP_DMULU, OP_DMULS:             mac_o = prod_i;
      OP_MAC32: begin
        if (!sat_i)      mac_o = mac_i + prod_i;
        else if (!ovf48) mac_o[47:0] = s48[47:0];
        else             mac_o[47:0] = s48[63] ? {1'b1, 47'b0} : {1'b0, {47{1'b1}}};
      end
      OP_MAC16: begin
        if (!sat_i) begin
          mac_o = mac_i + {{32{prod_i[31]}}, prod_i[31:0]};
        end else if (!ovf32) begin
          mac_o[31:0] = s33[31:0];
        end else begin
          mac_o[31:0] = s33[32] ? 32'h8000_0000 : 32'h7FFF_FFFF;
          mac_o[32]   = 1'b1;
        end
      end
      OP_LDH:  mac_o[63:32] = a_i;
      OP_LDL:  mac_o[31:0]  = a_i;
      default: mac_o = mac_i;
    endcase
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] opa_i,
  input  logic [WORD_W-1:0] opb_i,
  input  logic              sat_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] mach_o,
  output logic [WORD_W-1:0] macl_o
);
  logic              accept, fire;
  logic [OP_W-1:0]   op_q;
  logic [WORD_W-1:0] a_q, b_q;
  logic              sat_q;
  logic [ACC_W-1:0]  mac_q, prod, mac_nxt;

  mac_ctrl #(.LAT(LAT)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .fire_o   (fire),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      sat_q <= 1'b0;
    end else if (accept) begin
      op_q  <= op_i;
      a_q   <= opa_i;
      b_q   <= opb_i;
      sat_q <= sat_i;
    end
  end

  mac_mult u_mult (
    .op_i   (op_q),
    .a_i    (a_q),
    .b_i    (b_q),
    .prod_o (prod)
  );

  mac_accum u_accum (
    .op_i   (op_q),
    .sat_i  (sat_q),
    .a_i    (a_q),
    .prod_i (prod),
    .mac_i  (mac_q),
    .mac_o  (mac_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mac_q <= '0;
    else if (fire) mac_q <= mac_nxt;
  end

  assign mach_o = mac_q[63:32];
  assign macl_o = mac_q[31:0];

  // R1
  mul_keep_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && (op_q == OP_MUL32 || op_q == OP_MULU16 || op_q == OP_MULS16))
      |=> $stable(mach_o));
  // R8
  ldh_keep_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op_q == OP_LDH) |=> $stable(macl_o));
  // R8
  ldl_keep_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op_q == OP_LDL) |=> $stable(mach_o));
  // R5
  sat48_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op_q == OP_MAC32 && sat_q) |=> $stable(mach_o[31:16]));
  // R7
  sat32_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op_q == OP_MAC16 && sat_q)
      |=> ($stable(mach_o[31:1]) && (mach_o[0] || !$past(mach_o[0]))));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> ($stable(mach_o) && $stable(macl_o)));
  // R9
  done_follows_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> done_o);
endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        sat = 1'b0;
  logic        busy, done;
  logic [31:0] mach, macl;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [63:0] exp_mac = '0;

  always #4 clk = ~clk;

  mac_unit #(.LAT(LAT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .op_i(op),
    .opa_i(opa), .opb_i(opb), .sat_i(sat),
    .busy_o(busy), .done_o(done), .mach_o(mach), .macl_o(macl)
  );

  function automatic logic [63:0] model(input logic [3:0] c, input logic [31:0] a,
                                        input logic [31:0] b, input logic s,
                                        input logic [63:0] m);
    longint sa, sb, p, t;
    logic [63:0] r;
    r  = m;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (c)
      4'd0: r[31:0] = a * b;
      4'd1: r[31:0] = {16'h0, a[15:0]} * {16'h0, b[15:0]};
      4'd2: begin
        p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        r[31:0] = p[31:0];
      end
      4'd3: r = {32'h0, a} * {32'h0, b};
      4'd4: r = sa * sb;
      4'd5: begin
        p = sa * sb;
        if (!s) r = m + p;
        else begin
          t = longint'($signed(m[47:0])) + p;
          if (t > 64'sh0000_7FFF_FFFF_FFFF) t = 64'sh0000_7FFF_FFFF_FFFF;
          else if (t < -64'sh0000_8000_0000_0000) t = -64'sh0000_8000_0000_0000;
          r[47:0] = t[47:0];
        end
      end
      4'd6: begin
        p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        if (!s) r = m + p;
        else begin
          t = longint'($signed(m[31:0])) + p;
          if (t > 64'sd2147483647) begin r[31:0] = 32'h7FFF_FFFF; r[32] = 1'b1; end
          else if (t < -64'sd2147483648) begin r[31:0] = 32'h8000_0000; r[32] = 1'b1; end
          else r[31:0] = t[31:0];
        end
      end
      4'd7: r[63:32] = a;
      4'd8: r[31:0] = a;
      default: r = m;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] c, input logic s);
    case (c)
      4'd0: return "R1";
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4: return "R3";
      4'd5: return s ? "R5" : "R4";
      4'd6: return s ? "R7" : "R6";
      4'd7, 4'd8: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                        input logic s);
    int k;
    logic [63:0] e;
    e = model(c, a, b, s, exp_mac);
    @(negedge clk);
    start = 1'b1; op = c; opa = a; opb = b; sat = s;
    k = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      k++;
      if (k == 1) chk("R9 busy", 64'(busy), 64'd1);
    end while (!done && k < 20);
    chk("R9 latency", 64'(k), 64'(LAT + 1));
    chk(tag_of(c, s), {mach, macl}, e);
    exp_mac = e;
    @(negedge clk);
    chk("R9 pulse", {62'd0, done, busy}, 64'd0);
  endtask

  logic [31:0] vals [8] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'h0000_FFFF, 32'h0000_8000, 32'h1234_5678};
  logic [63:0] pres [5] = '{64'h0, 64'h1234_7FFF_FFFF_FFF0, 64'hABCD_8000_0000_0010,
                            64'h0000_0000_7FFF_FFF0, 64'h0000_0003_8000_0010};
  logic [3:0]  ops  [10] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd15};

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int dones;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", {mach, macl}, 64'd0);
    chk("R11 flags", {62'd0, busy, done}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    foreach (ops[i]) begin
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          for (int ip = 0; ip < 5; ip++) begin
            for (int s = 0; s < 2; s++) begin
              if (s == 1 && ops[i] != 4'd5 && ops[i] != 4'd6) continue;
              run_op(4'd7, pres[ip][63:32], 32'h0, 1'b0);
              run_op(4'd8, pres[ip][31:0], 32'h0, 1'b0);
              run_op(ops[i], vals[ia], vals[ib], s[0]);
            end
          end
        end
      end
    end

    // R10: start while busy is dropped
    run_op(4'd7, 32'h1111_2222, 32'h0, 1'b0);
    run_op(4'd8, 32'h3333_4444, 32'h0, 1'b0);
    @(negedge clk);
    start = 1'b1; op = 4'd0; opa = 32'd3; opb = 32'd5; sat = 1'b0;
    @(negedge clk);
    op = 4'd7; opa = 32'hDEAD_BEEF;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    repeat (8) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R10 single done", 64'(dones), 64'd1);
    chk("R10 busy start ignored", {mach, macl}, 64'h1111_2222_0000_000F);
    exp_mac = 64'h1111_2222_0000_000F;
    run_op(4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule